// File: doc/BRIEF.md
# Cascaded Search Result Arbiter

Several search-table devices are chained in depth and share one result bus. Every device gets the same search key in the same cycle. Each device then reports two things: whether it found a match, and the position of its best match inside its own table. This arbiter takes those per-device reports and picks one winner. The winner is the device whose match is closest to global address 0. Device 0 holds the lowest global addresses. The arbiter gives the winning device the drive-enable for the shared bus and forms the global index of the match. That index is the device number times the per-device depth, plus the local index.

Arbitration needs time to settle across the cascade, so the result goes through a fixed pipeline of `LATENCY` clock edges (at least 2). The global index, the result-valid strobe, the hit strobe and the per-device drive-enables all pass through this same pipeline. They therefore reach the receiver on the same edge. A new search may enter on every cycle, and results leave in the order the searches arrived.

The arbiter also merges the full flags of all the devices into one cascade-full output.

Top module: `cascade_result_arbiter`

## Requirements
- R1: While reset is high, and on the first edge after it rises, the arbiter clears the pending results. Its outputs then show res_valid=0, res_hit=0, drive_en=0, res_index=0 and cascade_full=0.
- R2: When exactly one device d hits with local index k, the result shows res_hit=1 and res_index = d*DEPTH + k. drive_en has only bit d set, where bit d belongs to device d.
- R3: When several devices hit, the device with the lowest number wins. The index and the drive-enable both come from that device, and the local indexes of the other devices have no effect.
- R4: A search in which no device hits gives res_valid=1, res_hit=0, res_index=0 and drive_en=0.
- R5: The result of a search sampled on clock edge E appears on the outputs on edge E+LATENCY-1. So the result arrives on the LATENCY-th edge, counting the sampling edge as the first. Index, valid, hit and drive-enables all change on that same edge, and res_valid stays low before it.
- R6: Searches may arrive on consecutive cycles. Each one produces its own result one cycle after the previous result, in the same order the searches arrived.
- R7: In a cycle with srch_valid=0, the dev_hit and dev_idx inputs are ignored. The matching output cycle shows res_valid=0, res_hit=0, drive_en=0 and res_index=0.
- R8: cascade_full goes high one edge after all dev_full bits are high at the same time. It goes low one edge after any dev_full bit goes low.
- R9: At most one drive_en bit is high in any cycle. A bit is high only when res_hit is high, and res_hit is high only when res_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srch_valid | input | 1 | A search is issued this cycle |
| dev_hit | input | N_DEV | Match flag per device, bit d for device d |
| dev_idx | input | N_DEV*LIDX_W | Local match index per device, device d in bits [d*LIDX_W +: LIDX_W] |
| dev_full | input | N_DEV | Table-full flag per device |
| res_valid | output | 1 | Result strobe, delayed by the pipeline |
| res_hit | output | 1 | The delayed search found a match |
| res_index | output | GIDX_W | Global index of the winning match |
| drive_en | output | N_DEV | Shared-bus drive-enable, one bit per device |
| cascade_full | output | 1 | Every device in the cascade is full |

## Verification
The assertions check several rules on every cycle. The winning device always has its own hit flag set, and no lower-numbered device has one. At most one drive-enable is high. A hit always comes with a valid result. The device field of the global index always matches the enabled device. A miss never drives the bus or shows a nonzero index. A full flag is high only if all devices were full one cycle earlier. Some properties can only be shown by the bench's scenarios: the exact latency in edges, the correct index arithmetic for chosen inputs, in-order delivery of back-to-back searches, the ignoring of hit inputs in idle cycles, and the clearing of results that are still in the pipeline when reset arrives.

// File: rtl/cascade_arb_pkg.sv
package cascade_arb_pkg;

    // Upper bound on the number of cascaded devices handled by the helpers.
    localparam int MAX_DEV = 32;

    // Result classification carried through the pipeline: bit 1 = valid, bit 0 = hit.
    typedef enum logic [1:0] {
        RES_IDLE = 2'b00,
        RES_MISS = 2'b10,
        RES_HIT  = 2'b11
    } res_kind_e;

    // Position of the lowest set bit, or MAX_DEV when none is set.
    function automatic int first_set(input logic [MAX_DEV-1:0] v);
        for (int i = 0; i < MAX_DEV; i++) begin
            if (v[i]) return i;
        end
        return MAX_DEV;
    endfunction

    // Classify a search outcome from the issue strobe and the merged hit flag.
    function automatic res_kind_e classify(input logic issued, input logic any_hit);
        if (!issued)  return RES_IDLE;
        if (any_hit)  return RES_HIT;
        return RES_MISS;
    endfunction

    function automatic logic kind_valid(input res_kind_e k);
        return k[1];
    endfunction

    function automatic logic kind_hit(input res_kind_e k);
        return k[0];
    endfunction

endpackage

// File: rtl/cascade_input_stage.sv
module cascade_input_stage #(
    parameter int N_DEV  = 4,
    parameter int LIDX_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    srch_valid,
    input  logic [N_DEV-1:0]        dev_hit,
    input  logic [N_DEV*LIDX_W-1:0] dev_idx,
    output logic                    srch_q,
    output logic [N_DEV-1:0]        hit_q,
    output logic [N_DEV*LIDX_W-1:0] idx_q
);

    // Hit flags are qualified by the issue strobe so idle cycles carry no hits.
    always_ff @(posedge clk) begin
        if (rst) begin
            srch_q <= 1'b0;
            hit_q  <= '0;
            idx_q  <= '0;
        end else begin
            srch_q <= srch_valid;
            hit_q  <= srch_valid ? dev_hit : '0;
            idx_q  <= dev_idx;
        end
    end

    // R7: no hit survives a cycle without a search
    a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !srch_q |-> (hit_q == '0));

endmodule

// File: rtl/cascade_prio_pick.sv
module cascade_prio_pick
    import cascade_arb_pkg::*;
#(
    parameter int N_DEV  = 4,
    parameter int LIDX_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DEV-1:0]        hit_vec,
    input  logic [N_DEV*LIDX_W-1:0] idx_flat,
    output logic                    any_hit,
    output int                      win_dev,
    output logic [N_DEV-1:0]        grant,
    output logic [LIDX_W-1:0]       win_local
);

    logic [LIDX_W-1:0] idx_arr [N_DEV];
    logic [N_DEV:0]    seen;

    assign seen[0] = 1'b0;

    // Prefix chain: a device wins when it hits and no lower device has hit.
    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        assign idx_arr[d]  = idx_flat[d*LIDX_W +: LIDX_W];
        assign seen[d+1]   = seen[d] | hit_vec[d];
        assign grant[d]    = hit_vec[d] & ~seen[d];
    end

    assign any_hit = seen[N_DEV];
    assign win_dev = first_set(MAX_DEV'(hit_vec));

    // AND-OR select of the winning local index.
    always_comb begin
        win_local = '0;
        for (int d = 0; d < N_DEV; d++) begin
            win_local = win_local | (idx_arr[d] & {LIDX_W{grant[d]}});
        end
    end

    // R3: the chain's winner is the lowest hitting device
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (grant[win_dev] && hit_vec[win_dev] &&
                     ((MAX_DEV'(hit_vec) & ((MAX_DEV'(1) << win_dev) - MAX_DEV'(1))) == '0)));

    // R9: the grant vector is one-hot exactly when some device hit
    a_r9_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant != '0) == (hit_vec != '0)));

endmodule

// File: rtl/cascade_delay_line.sv
module cascade_delay_line #(
    parameter int W      = 8,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    if (STAGES == 0) begin : g_bypass
        assign dout = din;
    end else begin : g_regs
        logic [W-1:0] pipe [STAGES];
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[s] <= '0;
                end else if (s == 0) begin
                    pipe[s] <= din;
                end else begin
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
        assign dout = pipe[STAGES-1];
    end

endmodule

// File: rtl/cascade_full_detect.sv
module cascade_full_detect #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] dev_full,
    output logic             all_full
);

    always_ff @(posedge clk) begin
        if (rst) all_full <= 1'b0;
        else     all_full <= &dev_full;
    end

    // R8: full only when every device was full on the previous edge
    a_r8_full_all: assert property (@(posedge clk) disable iff (rst)
        all_full |-> $past(dev_full == '1));

endmodule

// File: rtl/cascade_result_arbiter.sv
module cascade_result_arbiter
    import cascade_arb_pkg::*;
#(
    parameter int N_DEV   = 4,
    parameter int DEPTH   = 1024,
    parameter int LATENCY = 3,
    parameter int LIDX_W  = $clog2(DEPTH),
    parameter int GIDX_W  = $clog2(N_DEV * DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    srch_valid,
    input  logic [N_DEV-1:0]        dev_hit,
    input  logic [N_DEV*LIDX_W-1:0] dev_idx,
    input  logic [N_DEV-1:0]        dev_full,
    output logic                    res_valid,
    output logic                    res_hit,
    output logic [GIDX_W-1:0]       res_index,
    output logic [N_DEV-1:0]        drive_en,
    output logic                    cascade_full
);

    localparam int TAIL = (LATENCY > 2) ? LATENCY - 2 : 0;

    typedef struct packed {
        res_kind_e         kind;
        logic [GIDX_W-1:0] gidx;
        logic [N_DEV-1:0]  grant;
    } result_t;

    localparam int RES_W = $bits(result_t);

    // Stage 1: capture the cascade reports.
    logic                    srch_q;
    logic [N_DEV-1:0]        hit_q;
    logic [N_DEV*LIDX_W-1:0] idx_q;

    cascade_input_stage #(.N_DEV(N_DEV), .LIDX_W(LIDX_W)) u_in (
        .clk(clk), .rst(rst), .srch_valid(srch_valid), .dev_hit(dev_hit),
        .dev_idx(dev_idx), .srch_q(srch_q), .hit_q(hit_q), .idx_q(idx_q)
    );

    // Arbitration among the captured reports.
    logic              any_hit;
    int                win_dev;
    logic [N_DEV-1:0]  grant;
    logic [LIDX_W-1:0] win_local;

    cascade_prio_pick #(.N_DEV(N_DEV), .LIDX_W(LIDX_W)) u_pick (
        .clk(clk), .rst(rst), .hit_vec(hit_q), .idx_flat(idx_q),
        .any_hit(any_hit), .win_dev(win_dev), .grant(grant), .win_local(win_local)
    );

    // Stage 2: register the settled decision.
    result_t res_next, res_q, res_out;

    always_comb begin
        res_next.kind  = classify(srch_q, any_hit);
        res_next.grant = grant;
        res_next.gidx  = '0;
        if (any_hit) begin
            res_next.gidx = GIDX_W'(win_dev) * GIDX_W'(DEPTH) + GIDX_W'(win_local);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_next;
    end

    // Remaining alignment stages keep index, strobes and enables together.
    logic [RES_W-1:0] tail_out;

    cascade_delay_line #(.W(RES_W), .STAGES(TAIL)) u_tail (
        .clk(clk), .rst(rst), .din(res_q), .dout(tail_out)
    );

    assign res_out   = result_t'(tail_out);
    assign res_valid = kind_valid(res_out.kind);
    assign res_hit   = kind_hit(res_out.kind);
    assign res_index = res_out.gidx;
    assign drive_en  = res_out.grant;

    cascade_full_detect #(.N_DEV(N_DEV)) u_full (
        .clk(clk), .rst(rst), .dev_full(dev_full), .all_full(cascade_full)
    );

    // R9: a single device drives the bus, and only on a hit
    a_r9_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_en) && ((drive_en != '0) == res_hit));

    // R9: a hit is always a valid result
    a_r9_hit_valid: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

    // R2: the device field of the global index names the enabled device
    a_r2_index_device: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (int'(res_index / GIDX_W'(DEPTH)) == first_set(MAX_DEV'(drive_en))));

    // R4: a miss shows no index and no driver
    a_r4_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_index == '0 && drive_en == '0));

endmodule

// File: tb/sim_cascade_result_arbiter.sv
module sim_cascade_result_arbiter;

    localparam int N   = 4;
    localparam int DEP = 1024;
    localparam int LAT = 3;
    localparam int LW  = 10;
    localparam int GW  = 12;
    localparam int NV  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          srch_valid = 1'b0;
    logic [N-1:0]  dev_hit = '0;
    logic [N*LW-1:0] dev_idx = '0;
    logic [N-1:0]  dev_full = '0;
    logic          res_valid, res_hit, cascade_full;
    logic [GW-1:0] res_index;
    logic [N-1:0]  drive_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cascade_result_arbiter #(.N_DEV(N), .DEPTH(DEP), .LATENCY(LAT)) u0 (
        .clk(clk), .rst(rst), .srch_valid(srch_valid), .dev_hit(dev_hit),
        .dev_idx(dev_idx), .dev_full(dev_full), .res_valid(res_valid),
        .res_hit(res_hit), .res_index(res_index), .drive_en(drive_en),
        .cascade_full(cascade_full)
    );

    typedef struct packed {
        logic [3:0]  hit;
        logic [9:0]  i3, i2, i1, i0;
        logic        ehit;
        logic [11:0] eidx;
        logic [3:0]  een;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'b0001, 10'd3,    10'd8,    10'd9,    10'd5,   1'b1, 12'd5,    4'b0001}, // R2 dev0
        '{4'b0100, 10'd1,    10'd1023, 10'd4,    10'd6,   1'b1, 12'd3071, 4'b0100}, // R2 dev2 top
        '{4'b1010, 10'd2,    10'd11,   10'd7,    10'd12,  1'b1, 12'd1031, 4'b0010}, // R3
        '{4'b0000, 10'd44,   10'd33,   10'd22,   10'd11,  1'b0, 12'd0,    4'b0000}, // R4
        '{4'b1111, 10'd5,    10'd6,    10'd1,    10'd900, 1'b1, 12'd900,  4'b0001}, // R3 all
        '{4'b1000, 10'd0,    10'd77,   10'd88,   10'd99,  1'b1, 12'd3072, 4'b1000}, // R2 dev3
        '{4'b1100, 10'd1,    10'd0,    10'd300,  10'd200, 1'b1, 12'd2048, 4'b0100}, // R3
        '{4'b0110, 10'd9,    10'd0,    10'd1023, 10'd8,   1'b1, 12'd2047, 4'b0010}  // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_vec(input vec_t v);
        srch_valid = 1'b1;
        dev_hit    = v.hit;
        dev_idx    = {v.i3, v.i2, v.i1, v.i0};
    endtask

    task automatic drive_idle();
        srch_valid = 1'b0;
        dev_hit    = 4'b1111;
        dev_idx    = {10'd1, 10'd2, 10'd3, 10'd4};
    endtask

    task automatic chk_vec(input string req, input vec_t v);
        chk({req, " valid"}, 32'(res_valid), 32'd1);
        chk({req, " hit"},   32'(res_hit),   32'(v.ehit));
        chk({req, " index"}, 32'(res_index), 32'(v.eidx));
        chk({req, " enable"},32'(drive_en),  32'(v.een));
    endtask

    task automatic chk_quiet(input string req);
        chk({req, " valid"}, 32'(res_valid), 32'd0);
        chk({req, " hit"},   32'(res_hit),   32'd0);
        chk({req, " index"}, 32'(res_index), 32'd0);
        chk({req, " enable"},32'(drive_en),  32'd0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        drive_idle();
        dev_full = 4'b1111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_quiet("R1 in reset");
        chk("R1 full in reset", 32'(cascade_full), 32'd0);
        dev_full = '0;
        rst = 1'b0;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        chk_quiet("R1 after release");

        // R5: single search, result only on the LAT-th edge
        drive_vec(VECS[0]);
        for (int e = 1; e <= LAT; e++) begin
            @(posedge clk);
            @(negedge clk);
            drive_idle();
            if (e < LAT) chk("R5 early valid", 32'(res_valid), 32'd0);
            else         chk_vec("R5 aligned", VECS[0]);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R5 single cycle pulse", 32'(res_valid), 32'd0);

        // R6: vector table streamed back to back, checked in order
        for (int c = 0; c < NV + LAT; c++) begin
            if (c >= LAT) chk_vec($sformatf("R6 stream vec%0d", c - LAT), VECS[c - LAT]);
            if (c < NV) drive_vec(VECS[c]);
            else        drive_idle();
            @(posedge clk);
            @(negedge clk);
        end

        // R7: hits during idle cycles are ignored
        drive_idle();
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        chk_quiet("R7 idle hits ignored");

        // R4: lone miss
        drive_vec(VECS[3]);
        repeat (LAT) begin
            @(posedge clk);
            @(negedge clk);
            drive_idle();
        end
        chk_vec("R4 miss", VECS[3]);

        // R8: cascade full
        dev_full = 4'b1110;
        @(posedge clk);
        @(negedge clk);
        chk("R8 partial full", 32'(cascade_full), 32'd0);
        dev_full = 4'b1111;
        chk("R8 not before edge", 32'(cascade_full), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 all full", 32'(cascade_full), 32'd1);
        dev_full = 4'b0111;
        @(posedge clk);
        @(negedge clk);
        chk("R8 drop", 32'(cascade_full), 32'd0);

        // R1: reset flushes results in flight
        drive_vec(VECS[1]);
        @(posedge clk);
        @(negedge clk);
        drive_vec(VECS[2]);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        drive_idle();
        for (int e = 0; e < LAT + 1; e++) begin
            chk("R1 flushed valid", 32'(res_valid), 32'd0);
            @(posedge clk);
            @(negedge clk);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule